// File: doc/BRIEF.md
# Serial Command Decoder with DAC Code Registers

This block is a three-wire serial slave. A frame opens when the active-low frame enable drops. Data bits are taken on rising edges of the shift clock, least significant bit first. The frame is acted on when the enable returns high, and only if exactly sixteen clock edges arrived in between. The four bits received first form an opcode. The twelve bits that follow form the payload.

The opcode does one of three things:
- It loads one of twelve 8-bit DAC code registers.
- It issues a group command that puts the DAC side of the eight pin-shared channels into high impedance.
- It hands the payload to a neighbouring I/O expander as a one-cycle operation strobe with a kind code.

The four dedicated channels power up at code 00h. The eight shared channels power up with their DAC output in high impedance.

All three serial inputs are asynchronous to the system clock. They are oversampled through synchronizers, so every shift-clock phase must last several system clocks. Only the digital register state is modelled.

Top module: `serdac_cmd`

## Requirements
- R1: While `rst` is high at a clock edge, every DAC code becomes 00h, every `dac_hiz` bit becomes 1 and `io_valid` becomes 0.
- R2: Frame bit k is the bit on `shift_din` at the k-th rising edge of `shift_clk` after `frame_en_n` falls, counting from 0. The opcode is bits 3..0 and the payload is bits 15..4.
- R3: Opcodes 1 to 12 load channel (opcode−1). The value loaded is frame bits 11..4, with bit 4 as the code LSB. Frame bits 15..12 are ignored. Channel c occupies `dac_codes[8c+7:8c]`.
- R4: Channels 0–3 are dedicated and channels 4–11 are shared. A write to shared channel c clears `dac_hiz[c−4]`. A write to a dedicated channel leaves `dac_hiz` unchanged.
- R5: Opcode 0 with frame bits 7..4 equal to 1101 sets all eight `dac_hiz` bits and leaves every DAC code unchanged.
- R6: Opcodes 13, 14 and 15 raise `io_valid` for exactly one clock. At the same time `io_kind` reads 0, 1 or 2 respectively and `io_data` carries frame bits 15..4. These opcodes change no DAC code and no `dac_hiz` bit.
- R7: A frame closed after any count of shift-clock edges other than 16 changes no register and raises no `io_valid`.
- R8: Opcode 0 with any other value in bits 7..4 changes no register and raises no `io_valid`.
- R9: The edge count restarts at every fall of `frame_en_n`, so a valid frame that follows an aborted one is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_en_n | input | 1 | Active-low frame enable, asynchronous |
| shift_clk | input | 1 | Serial shift clock, asynchronous |
| shift_din | input | 1 | Serial data, sampled on rising `shift_clk` |
| dac_codes | output | 96 | Twelve 8-bit DAC codes, channel c at bits 8c+7..8c |
| dac_hiz | output | 8 | High-impedance flag of shared channels 4..11 (bit i = channel 4+i) |
| io_valid | output | 1 | One-cycle strobe of an I/O expander operation |
| io_kind | output | 2 | 0 output write, 1 capture, 2 direction setup, 3 idle |
| io_data | output | 12 | Payload handed to the I/O expander |

## Verification
The bench mixes random frames of random length and opcode with directed cases. The directed cases cover frames one bit short or one bit long, an aborted frame followed by a good one, an opcode-0 frame one bit away from the tri-state pattern, and a reset in the middle of the run.

Each failure shows up as a specific symptom:
- A decoder that ignores the length count would commit truncated frames, which shows as stray code changes.
- A decoder that reads bits MSB-first would load codes into the wrong channel.
- A tri-state decode that checks too few bits would flag every shared channel on a neighbouring pattern.
- Flags that do not clear on a shared write would leave channels stuck in high impedance.
- I/O opcodes that leak into the DAC bank would show up as changed codes after an expander operation.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int FRAME_BITS  = 16;
  localparam int OP_BITS     = 4;
  localparam int PAY_BITS    = FRAME_BITS - OP_BITS;
  localparam int CODE_BITS   = 8;
  localparam int NUM_CH      = 12;
  localparam int NUM_DED     = 4;
  localparam int NUM_SHARED  = NUM_CH - NUM_DED;
  localparam int CH_W        = $clog2(NUM_CH);
  localparam logic [3:0] TRI_PATTERN = 4'b1101;

  typedef enum logic [1:0] {
    IOK_DRIVE   = 2'd0,
    IOK_CAPTURE = 2'd1,
    IOK_DIRSET  = 2'd2,
    IOK_IDLE    = 2'd3
  } io_kind_e;

  // opcodes 1..NUM_CH address DAC channels
  function automatic logic op_is_dac(input logic [OP_BITS-1:0] op);
    return (op != '0) && (int'(op) <= NUM_CH);
  endfunction

  function automatic logic [CH_W-1:0] op_to_channel(input logic [OP_BITS-1:0] op);
    return CH_W'(op - OP_BITS'(1));
  endfunction

  function automatic logic op_is_tristate(input logic [OP_BITS-1:0] op,
                                          input logic [PAY_BITS-1:0] pay);
    return (op == '0) && (pay[3:0] == TRI_PATTERN);
  endfunction

  function automatic logic op_is_io(input logic [OP_BITS-1:0] op);
    return int'(op) > NUM_CH;
  endfunction

  function automatic io_kind_e op_to_io_kind(input logic [OP_BITS-1:0] op);
    io_kind_e k;
    unique case (op)
      4'd13:   k = IOK_DRIVE;
      4'd14:   k = IOK_CAPTURE;
      4'd15:   k = IOK_DIRSET;
      default: k = IOK_IDLE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/sdf_sync.sv
module sdf_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= async_in;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign level = pipe[STAGES-1];
endmodule

// File: rtl/sdf_shifter.sv
module sdf_shifter #(
  parameter int FRAME_BITS = sdf_pkg::FRAME_BITS,
  localparam int CW = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en_n_lvl,
  input  logic                  sclk_lvl,
  input  logic                  sdi_lvl,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  frame_done
);
  localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] OVER = CW'(FRAME_BITS + 1);

  logic          en_n_q, sclk_q;
  logic [CW-1:0] cnt;
  logic          en_start, en_end, sclk_rise;

  assign en_start  = en_n_q & ~en_n_lvl;
  assign en_end    = ~en_n_q & en_n_lvl;
  assign sclk_rise = sclk_lvl & ~sclk_q & ~en_n_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_n_q <= 1'b1;
      sclk_q <= 1'b0;
      cnt    <= '0;
      frame  <= '0;
    end else begin
      en_n_q <= en_n_lvl;
      sclk_q <= sclk_lvl;
      if (en_start) begin
        cnt <= '0;                       // R9 restart
      end else if (sclk_rise) begin
        frame <= {sdi_lvl, frame[FRAME_BITS-1:1]};   // R2 first bit ends at bit 0
        if (cnt != OVER) cnt <= cnt + CW'(1);
      end
    end
  end

  assign frame_done = en_end & (cnt == FULL);  // R7
endmodule

// File: rtl/sdf_dispatch.sv
module sdf_dispatch
  import sdf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  frame_done,
  output logic                  wr_dac,
  output logic [CH_W-1:0]       wr_ch,
  output logic [CODE_BITS-1:0]  wr_code,
  output logic                  wr_hiz,
  output logic                  io_fire,
  output logic                  io_valid,
  output logic [1:0]            io_kind,
  output logic [PAY_BITS-1:0]   io_data
);
  logic [OP_BITS-1:0]  op;
  logic [PAY_BITS-1:0] pay;

  assign op      = frame[OP_BITS-1:0];
  assign pay     = frame[FRAME_BITS-1:OP_BITS];
  assign wr_dac  = frame_done & op_is_dac(op);          // R3
  assign wr_ch   = op_to_channel(op);
  assign wr_code = pay[CODE_BITS-1:0];
  assign wr_hiz  = frame_done & op_is_tristate(op, pay); // R5 R8
  assign io_fire = frame_done & op_is_io(op);            // R6

  always_ff @(posedge clk) begin
    if (rst) begin
      io_valid <= 1'b0;
      io_kind  <= IOK_IDLE;
      io_data  <= '0;
    end else begin
      io_valid <= io_fire;
      if (io_fire) begin
        io_kind <= op_to_io_kind(op);
        io_data <= pay;
      end
    end
  end
endmodule

// File: rtl/sdf_dac_bank.sv
module sdf_dac_bank
  import sdf_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_dac,
  input  logic [CH_W-1:0]             wr_ch,
  input  logic [CODE_BITS-1:0]        wr_code,
  input  logic                        wr_hiz,
  output logic [NUM_CH*CODE_BITS-1:0] dac_codes,
  output logic [NUM_SHARED-1:0]       dac_hiz
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_code
    logic [CODE_BITS-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst)                                 code_q <= '0;       // R1
      else if (wr_dac && wr_ch == CH_W'(c))    code_q <= wr_code;  // R3
    end
    assign dac_codes[c*CODE_BITS +: CODE_BITS] = code_q;
  end

  for (genvar s = 0; s < NUM_SHARED; s++) begin : g_hiz
    logic hiz_q;
    always_ff @(posedge clk) begin
      if (rst)                                          hiz_q <= 1'b1; // R1
      else if (wr_hiz)                                  hiz_q <= 1'b1; // R5
      else if (wr_dac && wr_ch == CH_W'(NUM_DED + s))   hiz_q <= 1'b0; // R4
    end
    assign dac_hiz[s] = hiz_q;
  end
endmodule

// File: rtl/serdac_cmd.sv
module serdac_cmd
  import sdf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        frame_en_n,
  input  logic                        shift_clk,
  input  logic                        shift_din,
  output logic [NUM_CH*CODE_BITS-1:0] dac_codes,
  output logic [NUM_SHARED-1:0]       dac_hiz,
  output logic                        io_valid,
  output logic [1:0]                  io_kind,
  output logic [PAY_BITS-1:0]         io_data
);
  logic [2:0]            lvl;
  logic [FRAME_BITS-1:0] frame;
  logic                  frame_done;
  logic                  wr_dac, wr_hiz, io_fire;
  logic [CH_W-1:0]       wr_ch;
  logic [CODE_BITS-1:0]  wr_code;

  sdf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({shift_din, shift_clk, frame_en_n}),
    .level(lvl)
  );

  sdf_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst(rst),
    .en_n_lvl(lvl[0]), .sclk_lvl(lvl[1]), .sdi_lvl(lvl[2]),
    .frame(frame), .frame_done(frame_done)
  );

  sdf_dispatch u_disp (
    .clk(clk), .rst(rst), .frame(frame), .frame_done(frame_done),
    .wr_dac(wr_dac), .wr_ch(wr_ch), .wr_code(wr_code), .wr_hiz(wr_hiz),
    .io_fire(io_fire), .io_valid(io_valid), .io_kind(io_kind), .io_data(io_data)
  );

  sdf_dac_bank u_bank (
    .clk(clk), .rst(rst), .wr_dac(wr_dac), .wr_ch(wr_ch), .wr_code(wr_code),
    .wr_hiz(wr_hiz), .dac_codes(dac_codes), .dac_hiz(dac_hiz)
  );
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker
  import sdf_pkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_CH*CODE_BITS-1:0] dac_codes,
  input logic [NUM_SHARED-1:0]       dac_hiz,
  input logic                        io_valid,
  input logic                        frame_done,
  input logic                        wr_hiz
);
  AST_RESET_VALUES: assert property (@(posedge clk)
    rst |=> (dac_codes == '0 && dac_hiz == '1 && !io_valid)); // R1

  AST_HOLD_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> ($stable(dac_codes) && $stable(dac_hiz))); // R7

  AST_TRISTATE_KEEPS_CODES: assert property (@(posedge clk) disable iff (rst)
    wr_hiz |=> ($stable(dac_codes) && dac_hiz == '1)); // R5

  AST_HIZ_SET_ONLY_BY_TRISTATE: assert property (@(posedge clk) disable iff (rst)
    ((dac_hiz & ~$past(dac_hiz)) != '0) |-> $past(wr_hiz)); // R4

  AST_IO_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    io_valid |=> !io_valid); // R6

  AST_IO_LEAVES_DAC: assert property (@(posedge clk) disable iff (rst)
    io_valid |-> ($stable(dac_codes) && $stable(dac_hiz))); // R6
endmodule

bind serdac_cmd sdf_checker u_chk (
  .clk(clk), .rst(rst), .dac_codes(dac_codes), .dac_hiz(dac_hiz),
  .io_valid(io_valid), .frame_done(frame_done), .wr_hiz(wr_hiz)
);

// File: tb/serdac_cmd_tb.sv
module serdac_cmd_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_en_n = 1'b1;
  logic        shift_clk = 1'b0;
  logic        shift_din = 1'b0;
  logic [95:0] dac_codes;
  logic [7:0]  dac_hiz;
  logic        io_valid;
  logic [1:0]  io_kind;
  logic [11:0] io_data;

  always #2.5 clk = ~clk;

  serdac_cmd u_dut (
    .clk(clk), .rst(rst), .frame_en_n(frame_en_n), .shift_clk(shift_clk),
    .shift_din(shift_din), .dac_codes(dac_codes), .dac_hiz(dac_hiz),
    .io_valid(io_valid), .io_kind(io_kind), .io_data(io_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [7:0]  m_code [12];
  logic [7:0]  m_hiz;
  int          m_io_cnt;
  logic [1:0]  m_io_kind;
  logic [11:0] m_io_data;

  int          io_seen = 0;
  logic [1:0]  io_kind_seen;
  logic [11:0] io_data_seen;

  always @(negedge clk) begin
    if (io_valid) begin
      io_seen++;
      io_kind_seen = io_kind;
      io_data_seen = io_data;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    foreach (m_code[i]) m_code[i] = 8'h00;
    m_hiz = 8'hFF;
  endfunction

  // Expected effect of a frame, restated from the requirements
  function automatic string model_apply(input logic [15:0] w, input int nbits);
    logic [3:0]  op  = w[3:0];
    logic [11:0] pay = w[15:4];
    m_io_cnt = 0;
    if (nbits != 16) return "R7";
    if (op == 4'd0) begin
      if (pay[3:0] == 4'b1101) begin m_hiz = 8'hFF; return "R5"; end
      return "R8";
    end
    if (op >= 4'd13) begin
      m_io_cnt  = 1;
      m_io_kind = 2'(op - 4'd13);
      m_io_data = pay;
      return "R6";
    end
    m_code[op - 1] = pay[7:0];
    if (op >= 4'd5) begin m_hiz[op - 5] = 1'b0; return "R4"; end
    return "R3";
  endfunction

  function automatic logic [95:0] model_flat();
    logic [95:0] f;
    for (int c = 0; c < 12; c++) f[c*8 +: 8] = m_code[c];
    return f;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    io_seen = 0;
    frame_en_n = 1'b0;
    wait_clk(5);
    for (int i = 0; i < nbits; i++) begin
      shift_din = w[i % 16];
      wait_clk(3);
      shift_clk = 1'b1;
      wait_clk(3);
      shift_clk = 1'b0;
    end
    wait_clk(4);
    frame_en_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic frame_and_check(input logic [15:0] w, input int nbits);
    string req;
    send(w, nbits);
    req = model_apply(w, nbits);
    check(req, "dac_codes", dac_codes, model_flat());
    check(req, "dac_hiz", {88'd0, dac_hiz}, {88'd0, m_hiz});
    check(req, "io strobe count", 96'(io_seen), 96'(m_io_cnt));
    if (m_io_cnt == 1) begin
      check(req, "io_kind", 96'(io_kind_seen), 96'(m_io_kind));
      check(req, "io_data", 96'(io_data_seen), 96'(m_io_data));
    end
  endtask

  task automatic check_reset_state();
    check("R1", "reset dac_codes", dac_codes, 96'd0);
    check("R1", "reset dac_hiz", {88'd0, dac_hiz}, {88'd0, 8'hFF});
    check("R1", "reset io_valid", 96'(io_valid), 96'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    model_reset();
    wait_clk(6);
    rst = 1'b0;
    wait_clk(2);
    check_reset_state();                         // R1

    // R3 dedicated channel, R2 LSB-first order (op 1 = bits 0001)
    frame_and_check(16'h0A51, 16);
    // R4 shared channel writes clear their flag
    frame_and_check(16'hF3C5, 16);
    frame_and_check(16'h077C, 16);
    // R5 tri-state, codes kept
    frame_and_check(16'hABD0, 16);
    // R8 neighbouring pattern on opcode 0
    frame_and_check(16'h00C0, 16);
    frame_and_check(16'h0050, 16);
    // R7 short and long frames
    frame_and_check(16'h5556, 15);
    frame_and_check(16'h9996, 17);
    // R9 aborted frame followed by a good one
    frame_and_check(16'h1238, 9);
    frame_and_check(16'h4428, 16);
    // R6 expander operations
    frame_and_check(16'h123D, 16);
    frame_and_check(16'hFEDE, 16);
    frame_and_check(16'h800F, 16);

    for (int k = 0; k < 260; k++) begin
      logic [15:0] w;
      int r, nb;
      w = 16'($urandom());
      if (w[3:0] == 4'd0 && $urandom_range(0, 1) == 1) w[7:4] = 4'b1101;
      r = $urandom_range(0, 9);
      nb = (r == 0) ? 15 : (r == 1) ? 17 : (r == 2) ? $urandom_range(1, 14) : 16;
      frame_and_check(w, nb);
      if (k == 130) begin
        @(negedge clk) rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(2);
        model_reset();
        check_reset_state();                     // R1 mid-run
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule